// File: doc/BRIEF.md
# Dual-Clock Two-Port Memory with Configurable Output Register

This block is a true two-port synchronous memory. Port A and port B each have their own clock, enable, write strobe, synchronous output clear, address, data and parity buses. Either port can read or write any word at any time, and each port works only on its own clock edge. Every stored word is the data bits with the parity bits on top. Parity passes through the memory and the output register under exactly the same rules as data.

Each port returns its read data through a registered output stage. Three parameters shape that stage, each chosen separately for each port:
- a write behaviour: show the new data, show the old data, or keep the previous output;
- a clear constant, loaded when the synchronous clear is active;
- a start value, loaded by the global reset.

The global reset is asynchronous. It also reloads the whole array from an image parameter, so the memory starts from known contents. When both ports write one word on the same edge, port A's write is kept.

Top module: `tdp_ram`

## Requirements
- R1: Both ports can act in the same cycle, each reading or writing its own address, with no effect of one port on the other's result except through the shared contents.
- R2: With the port enable low, the output register keeps its value and the array is not written, even if the write strobe is high.
- R3: With enable high, clear high and write strobe low, the output register loads that port's clear constant one edge later, and the array is unchanged.
- R4: With enable high, clear high and write strobe high, the output register loads the clear constant and the input word is still stored at the address.
- R5: With enable high, clear low and write strobe low, the output register holds the addressed word after that same edge (one cycle of read latency).
- R6: In show-new mode, a write also loads the written word into the output register.
- R7: In show-old mode, a write loads the contents the address held before the edge into the output register.
- R8: In keep-output mode, a write leaves the output register unchanged.
- R9: While the global reset is high, each output register equals its start-value parameter. After reset, word i of the array equals bits [i*W +: W] of the image parameter, where W = DATA_W + PAR_W.
- R10: A stored word is {parity, data}: parity in the upper PAR_W bits and data in the lower DATA_W bits. Both come back together on the outputs.
- R11: When both ports write the same address on the same clock edge, a later read returns port A's word.
- R12: A port that reads an address while the other port writes it on the same edge gets the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| grst | input | 1 | Asynchronous global reset, active high; reloads the array and output registers |
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write strobe |
| ssr_a | input | 1 | Port A synchronous output clear |
| addr_a | input | ADDR_W | Port A word address |
| din_a | input | DATA_W | Port A write data |
| pin_a | input | PAR_W | Port A write parity |
| dout_a | output | DATA_W | Port A registered read data |
| pout_a | output | PAR_W | Port A registered read parity |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write strobe |
| ssr_b | input | 1 | Port B synchronous output clear |
| addr_b | input | ADDR_W | Port B word address |
| din_b | input | DATA_W | Port B write data |
| pin_b | input | PAR_W | Port B write parity |
| dout_b | output | DATA_W | Port B registered read data |
| pout_b | output | PAR_W | Port B registered read parity |

## Verification
The hardest case to reach from the ports is two ports acting on one word on the same edge, either as two writes or as a write against a read. Those outcomes only show up when the edges really coincide. The bench therefore drives both port clocks from one source and sets up both collision forms on purpose. It then reads the word back on a later cycle, so the arbitration result appears at the outputs. The keep-output mode cannot be combined with the other modes on the same port, so a second instance built with that mode runs beside the first on identical stimulus. A long pseudo-random run then mixes clears, writes and disabled cycles against a reference model.

// File: rtl/tdp_ram_pkg.sv
package tdp_ram_pkg;

   // Output register behaviour when the port writes.
   typedef enum logic [1:0] {
      WM_SHOW_NEW  = 2'd0,
      WM_SHOW_OLD  = 2'd1,
      WM_KEEP_OUT  = 2'd2
   } wr_mode_e;

endpackage

// File: rtl/tdp_ram_bank.sv
// One write bank of the two-port array. Each bank is written only by its
// own port's clock. A one-bit tag per word records which bank holds the
// newest copy of that word.
module tdp_ram_bank #(
   parameter int ADDR_W = 6,
   parameter int WORD_W = 9,
   parameter bit TAG_INV = 1'b0,
   parameter logic [(2**ADDR_W)*WORD_W-1:0] INIT_IMG = '0
) (
   input  logic              clk,
   input  logic              grst,
   input  logic              wr,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              peer_tag_w,
   input  logic [ADDR_W-1:0] raddr0,
   input  logic [ADDR_W-1:0] raddr1,
   output logic [WORD_W-1:0] rdata0,
   output logic [WORD_W-1:0] rdata1,
   output logic              rtag0,
   output logic              rtag1
);

   localparam int DEPTH = 2**ADDR_W;

   logic [WORD_W-1:0] mem_q [DEPTH];
   logic              tag_q [DEPTH];

   always_ff @(posedge clk or posedge grst) begin
      if (grst) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= INIT_IMG[i*WORD_W +: WORD_W];
            tag_q[i] <= 1'b0;
         end
      end else if (wr) begin
         mem_q[waddr] <= wdata;
         tag_q[waddr] <= peer_tag_w ^ TAG_INV;
      end
   end

   assign rdata0 = mem_q[raddr0];
   assign rdata1 = mem_q[raddr1];
   assign rtag0  = tag_q[raddr0];
   assign rtag1  = tag_q[raddr1];

endmodule

// File: rtl/tdp_ram_outreg.sv
// Per-port registered output stage. A generate branch fixes the write
// behaviour at elaboration.
module tdp_ram_outreg
   import tdp_ram_pkg::*;
#(
   parameter int WORD_W = 9,
   parameter wr_mode_e MODE = WM_SHOW_NEW,
   parameter logic [WORD_W-1:0] CLR_VAL = '0,
   parameter logic [WORD_W-1:0] START_VAL = '0
) (
   input  logic              clk,
   input  logic              grst,
   input  logic              en,
   input  logic              ssr,
   input  logic              we,
   input  logic [WORD_W-1:0] rd_word,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] q
);

   logic [WORD_W-1:0] wr_val;

   generate
      if (MODE == WM_SHOW_NEW) begin : g_new
         assign wr_val = wdata;
      end else if (MODE == WM_SHOW_OLD) begin : g_old
         assign wr_val = rd_word;
      end else begin : g_keep
         assign wr_val = q;
      end
   endgenerate

   always_ff @(posedge clk or posedge grst) begin
      if (grst) begin
         q <= START_VAL;
      end else if (en) begin
         if (ssr)     q <= CLR_VAL;
         else if (we) q <= wr_val;
         else         q <= rd_word;
      end
   end

endmodule

// File: rtl/tdp_ram.sv
module tdp_ram
   import tdp_ram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8,
   parameter int PAR_W  = 1,
   parameter wr_mode_e MODE_A = WM_SHOW_NEW,
   parameter wr_mode_e MODE_B = WM_SHOW_NEW,
   parameter logic [DATA_W+PAR_W-1:0] CLR_A   = '0,
   parameter logic [DATA_W+PAR_W-1:0] CLR_B   = '0,
   parameter logic [DATA_W+PAR_W-1:0] START_A = '0,
   parameter logic [DATA_W+PAR_W-1:0] START_B = '0,
   parameter logic [(2**ADDR_W)*(DATA_W+PAR_W)-1:0] MEM_IMG = '0
) (
   input  logic              grst,
   input  logic              clk_a,
   input  logic              en_a,
   input  logic              we_a,
   input  logic              ssr_a,
   input  logic [ADDR_W-1:0] addr_a,
   input  logic [DATA_W-1:0] din_a,
   input  logic [PAR_W-1:0]  pin_a,
   output logic [DATA_W-1:0] dout_a,
   output logic [PAR_W-1:0]  pout_a,
   input  logic              clk_b,
   input  logic              en_b,
   input  logic              we_b,
   input  logic              ssr_b,
   input  logic [ADDR_W-1:0] addr_b,
   input  logic [DATA_W-1:0] din_b,
   input  logic [PAR_W-1:0]  pin_b,
   output logic [DATA_W-1:0] dout_b,
   output logic [PAR_W-1:0]  pout_b
);

   localparam int WORD_W = DATA_W + PAR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("tdp_ram: ADDR_W must lie in 1..16");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("tdp_ram: DATA_W must be at least 1");
      end
      if (PAR_W < 1) begin : g_bad_par
         $error("tdp_ram: PAR_W must be at least 1");
      end
   endgenerate

   // Stored words: parity above data.
   logic [WORD_W-1:0] wword_a, wword_b;
   assign wword_a = {pin_a, din_a};
   assign wword_b = {pin_b, din_b};

   // Write qualification; port A wins a same-address write collision.
   logic wr_a, wr_b, clash;
   assign wr_a  = en_a & we_a;
   assign clash = wr_a && (addr_a == addr_b);
   assign wr_b  = en_b & we_b & ~clash;

   logic [WORD_W-1:0] bka_at_a, bka_at_b, bkb_at_a, bkb_at_b;
   logic              tga_at_a, tga_at_b, tgb_at_a, tgb_at_b;

   tdp_ram_bank #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .TAG_INV(1'b0), .INIT_IMG(MEM_IMG)
   ) u_bank_a (
      .clk(clk_a), .grst(grst), .wr(wr_a), .waddr(addr_a), .wdata(wword_a),
      .peer_tag_w(tgb_at_a), .raddr0(addr_a), .raddr1(addr_b),
      .rdata0(bka_at_a), .rdata1(bka_at_b), .rtag0(tga_at_a), .rtag1(tga_at_b)
   );

   tdp_ram_bank #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .TAG_INV(1'b1), .INIT_IMG('0)
   ) u_bank_b (
      .clk(clk_b), .grst(grst), .wr(wr_b), .waddr(addr_b), .wdata(wword_b),
      .peer_tag_w(tga_at_b), .raddr0(addr_a), .raddr1(addr_b),
      .rdata0(bkb_at_a), .rdata1(bkb_at_b), .rtag0(tgb_at_a), .rtag1(tgb_at_b)
   );

   // Equal tags mean bank A holds the live copy.
   logic [WORD_W-1:0] live_a, live_b;
   assign live_a = (tga_at_a == tgb_at_a) ? bka_at_a : bkb_at_a;
   assign live_b = (tga_at_b == tgb_at_b) ? bka_at_b : bkb_at_b;

   logic [WORD_W-1:0] q_a, q_b;

   tdp_ram_outreg #(
      .WORD_W(WORD_W), .MODE(MODE_A), .CLR_VAL(CLR_A), .START_VAL(START_A)
   ) u_out_a (
      .clk(clk_a), .grst(grst), .en(en_a), .ssr(ssr_a), .we(we_a),
      .rd_word(live_a), .wdata(wword_a), .q(q_a)
   );

   tdp_ram_outreg #(
      .WORD_W(WORD_W), .MODE(MODE_B), .CLR_VAL(CLR_B), .START_VAL(START_B)
   ) u_out_b (
      .clk(clk_b), .grst(grst), .en(en_b), .ssr(ssr_b), .we(we_b),
      .rd_word(live_b), .wdata(wword_b), .q(q_b)
   );

   assign dout_a = q_a[DATA_W-1:0];
   assign pout_a = q_a[WORD_W-1 -: PAR_W];
   assign dout_b = q_b[DATA_W-1:0];
   assign pout_b = q_b[WORD_W-1 -: PAR_W];

endmodule

// File: rtl/tdp_ram_chk.sv
module tdp_ram_chk
   import tdp_ram_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PAR_W  = 1,
   parameter wr_mode_e MODE_A = WM_SHOW_NEW,
   parameter wr_mode_e MODE_B = WM_SHOW_NEW,
   parameter logic [DATA_W+PAR_W-1:0] CLR_A   = '0,
   parameter logic [DATA_W+PAR_W-1:0] CLR_B   = '0,
   parameter logic [DATA_W+PAR_W-1:0] START_A = '0,
   parameter logic [DATA_W+PAR_W-1:0] START_B = '0
) (
   input logic              grst,
   input logic              clk_a,
   input logic              en_a,
   input logic              we_a,
   input logic              ssr_a,
   input logic [DATA_W-1:0] din_a,
   input logic [PAR_W-1:0]  pin_a,
   input logic [DATA_W-1:0] dout_a,
   input logic [PAR_W-1:0]  pout_a,
   input logic              clk_b,
   input logic              en_b,
   input logic              we_b,
   input logic              ssr_b,
   input logic [DATA_W-1:0] din_b,
   input logic [PAR_W-1:0]  pin_b,
   input logic [DATA_W-1:0] dout_b,
   input logic [PAR_W-1:0]  pout_b
);

   AST_A_RST_START: assert property (@(posedge clk_a) grst |-> {pout_a, dout_a} == START_A); // R9
   AST_B_RST_START: assert property (@(posedge clk_b) grst |-> {pout_b, dout_b} == START_B); // R9

   AST_A_HOLD_OFF: assert property (@(posedge clk_a) disable iff (grst)
      !en_a |=> $stable({pout_a, dout_a})); // R2
   AST_B_HOLD_OFF: assert property (@(posedge clk_b) disable iff (grst)
      !en_b |=> $stable({pout_b, dout_b})); // R2

   AST_A_CLEAR: assert property (@(posedge clk_a) disable iff (grst)
      en_a && ssr_a |=> {pout_a, dout_a} == CLR_A); // R3
   AST_B_CLEAR: assert property (@(posedge clk_b) disable iff (grst)
      en_b && ssr_b |=> {pout_b, dout_b} == CLR_B); // R3

   AST_A_SHOW_NEW: assert property (@(posedge clk_a) disable iff (grst)
      (MODE_A == WM_SHOW_NEW) && en_a && !ssr_a && we_a
      |=> {pout_a, dout_a} == $past({pin_a, din_a})); // R6
   AST_B_SHOW_NEW: assert property (@(posedge clk_b) disable iff (grst)
      (MODE_B == WM_SHOW_NEW) && en_b && !ssr_b && we_b
      |=> {pout_b, dout_b} == $past({pin_b, din_b})); // R6

   AST_A_KEEP_OUT: assert property (@(posedge clk_a) disable iff (grst)
      (MODE_A == WM_KEEP_OUT) && en_a && !ssr_a && we_a
      |=> $stable({pout_a, dout_a})); // R8
   AST_B_KEEP_OUT: assert property (@(posedge clk_b) disable iff (grst)
      (MODE_B == WM_KEEP_OUT) && en_b && !ssr_b && we_b
      |=> $stable({pout_b, dout_b})); // R8

endmodule

bind tdp_ram tdp_ram_chk #(
   .DATA_W(DATA_W), .PAR_W(PAR_W), .MODE_A(MODE_A), .MODE_B(MODE_B),
   .CLR_A(CLR_A), .CLR_B(CLR_B), .START_A(START_A), .START_B(START_B)
) u_chk (
   .grst(grst),
   .clk_a(clk_a), .en_a(en_a), .we_a(we_a), .ssr_a(ssr_a),
   .din_a(din_a), .pin_a(pin_a), .dout_a(dout_a), .pout_a(pout_a),
   .clk_b(clk_b), .en_b(en_b), .we_b(we_b), .ssr_b(ssr_b),
   .din_b(din_b), .pin_b(pin_b), .dout_b(dout_b), .pout_b(pout_b)
);

// File: tb/tb_tdp_ram.sv
`timescale 1ns/1ps
module tb_tdp_ram;
   import tdp_ram_pkg::*;

   localparam int AW = 4;
   localparam int DW = 8;
   localparam int PW = 1;
   localparam int WW = DW + PW;
   localparam int DEPTH = 2**AW;
   localparam logic [WW-1:0] CLR_A = 9'h155;
   localparam logic [WW-1:0] CLR_B = 9'h0AA;
   localparam logic [WW-1:0] ST_A  = 9'h1F0;
   localparam logic [WW-1:0] ST_B  = 9'h00F;

   function automatic logic [WW-1:0] img_word(input int i);
      return WW'((i * 37 + 11) % 512);
   endfunction

   function automatic logic [DEPTH*WW-1:0] make_img();
      logic [DEPTH*WW-1:0] v;
      for (int i = 0; i < DEPTH; i++) v[i*WW +: WW] = img_word(i);
      return v;
   endfunction

   localparam logic [DEPTH*WW-1:0] IMG = make_img();

   typedef struct {
      logic          en, we, ssr;
      logic [AW-1:0] addr;
      logic [DW-1:0] din;
      logic [PW-1:0] pin;
   } op_t;

   typedef struct {
      logic [WW-1:0] exp [4];
      string         req;
   } item_t;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic grst;
   logic en_a, we_a, ssr_a, en_b, we_b, ssr_b;
   logic [AW-1:0] addr_a, addr_b;
   logic [DW-1:0] din_a, din_b;
   logic [PW-1:0] pin_a, pin_b;
   logic [DW-1:0] dout_a, dout_b, ndout_a, ndout_b;
   logic [PW-1:0] pout_a, pout_b, npout_a, npout_b;

   tdp_ram #(
      .ADDR_W(AW), .DATA_W(DW), .PAR_W(PW), .MODE_A(WM_SHOW_NEW), .MODE_B(WM_SHOW_OLD),
      .CLR_A(CLR_A), .CLR_B(CLR_B), .START_A(ST_A), .START_B(ST_B), .MEM_IMG(IMG)
   ) dut (
      .grst(grst), .clk_a(clk), .en_a(en_a), .we_a(we_a), .ssr_a(ssr_a), .addr_a(addr_a),
      .din_a(din_a), .pin_a(pin_a), .dout_a(dout_a), .pout_a(pout_a),
      .clk_b(clk), .en_b(en_b), .we_b(we_b), .ssr_b(ssr_b), .addr_b(addr_b),
      .din_b(din_b), .pin_b(pin_b), .dout_b(dout_b), .pout_b(pout_b)
   );

   tdp_ram #(
      .ADDR_W(AW), .DATA_W(DW), .PAR_W(PW), .MODE_A(WM_KEEP_OUT), .MODE_B(WM_KEEP_OUT),
      .CLR_A(CLR_A), .CLR_B(CLR_B), .START_A(ST_A), .START_B(ST_B), .MEM_IMG(IMG)
   ) dut_nc (
      .grst(grst), .clk_a(clk), .en_a(en_a), .we_a(we_a), .ssr_a(ssr_a), .addr_a(addr_a),
      .din_a(din_a), .pin_a(pin_a), .dout_a(ndout_a), .pout_a(npout_a),
      .clk_b(clk), .en_b(en_b), .we_b(we_b), .ssr_b(ssr_b), .addr_b(addr_b),
      .din_b(din_b), .pin_b(pin_b), .dout_b(ndout_b), .pout_b(npout_b)
   );

   int vectors = 0;
   int fails = 0;
   bit done = 0;
   item_t sb_q[$];
   logic [WW-1:0] mdl_mem [DEPTH];
   logic [WW-1:0] prev [4];

   function automatic logic [WW-1:0] actual(input int k);
      case (k)
         0: return {pout_a, dout_a};
         1: return {pout_b, dout_b};
         2: return {npout_a, ndout_a};
         default: return {npout_b, ndout_b};
      endcase
   endfunction

   function automatic logic [WW-1:0] nxt(input wr_mode_e m, input op_t o, input logic [WW-1:0] old,
                                         input logic [WW-1:0] p, input logic [WW-1:0] clr);
      if (!o.en) return p;
      if (o.ssr) return clr;
      if (o.we) begin
         if (m == WM_SHOW_NEW) return {o.pin, o.din};
         if (m == WM_SHOW_OLD) return old;
         return p;
      end
      return old;
   endfunction

   task automatic cmp(input int k, input logic [WW-1:0] exp, input string req);
      logic [WW-1:0] got;
      got = actual(k);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s out%0d got %h expected %h at %0t", req, k, got, exp, $time);
      end
   endtask

   function automatic void model_reset();
      for (int i = 0; i < DEPTH; i++) mdl_mem[i] = img_word(i);
      prev[0] = ST_A; prev[1] = ST_B; prev[2] = ST_A; prev[3] = ST_B;
   endfunction

   // Driver: apply one vector per clock and push the expected outputs.
   task automatic drive(input op_t a, input op_t b, input string req);
      item_t it;
      logic [WW-1:0] old_a, old_b;
      @(negedge clk);
      en_a = a.en; we_a = a.we; ssr_a = a.ssr; addr_a = a.addr; din_a = a.din; pin_a = a.pin;
      en_b = b.en; we_b = b.we; ssr_b = b.ssr; addr_b = b.addr; din_b = b.din; pin_b = b.pin;
      old_a = mdl_mem[a.addr];
      old_b = mdl_mem[b.addr];
      prev[0] = nxt(WM_SHOW_NEW, a, old_a, prev[0], CLR_A);
      prev[1] = nxt(WM_SHOW_OLD, b, old_b, prev[1], CLR_B);
      prev[2] = nxt(WM_KEEP_OUT, a, old_a, prev[2], CLR_A);
      prev[3] = nxt(WM_KEEP_OUT, b, old_b, prev[3], CLR_B);
      if (a.en && a.we) mdl_mem[a.addr] = {a.pin, a.din};
      if (b.en && b.we && !(a.en && a.we && a.addr == b.addr)) mdl_mem[b.addr] = {b.pin, b.din};
      for (int k = 0; k < 4; k++) it.exp[k] = prev[k];
      it.req = req;
      sb_q.push_back(it);
   endtask

   // Monitor: compare just after each edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            for (int k = 0; k < 4; k++) cmp(k, it.exp[k], it.req);
         end
      end
   end

   function automatic op_t rd(input int ad);
      op_t o;
      o.en = 1; o.we = 0; o.ssr = 0; o.addr = AW'(ad); o.din = '0; o.pin = '0;
      return o;
   endfunction

   function automatic op_t wr(input int ad, input logic [WW-1:0] w);
      op_t o;
      o = rd(ad);
      o.we = 1; o.din = w[DW-1:0]; o.pin = w[WW-1 -: PW];
      return o;
   endfunction

   function automatic op_t off();
      op_t o;
      o = rd(0);
      o.en = 0;
      return o;
   endfunction

   task automatic check_start(input string req);
      cmp(0, ST_A, req); cmp(1, ST_B, req); cmp(2, ST_A, req); cmp(3, ST_B, req);
   endtask

   task automatic pulse_reset();
      @(negedge clk);
      grst = 1'b1;
      #2;
      check_start("R9 reset mid-run");
      @(negedge clk);
      grst = 1'b0;
      model_reset();
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      op_t a, b;
      logic [31:0] lfsr;
      grst = 1'b1;
      en_a = 0; we_a = 0; ssr_a = 0; addr_a = '0; din_a = '0; pin_a = '0;
      en_b = 0; we_b = 0; ssr_b = 0; addr_b = '0; din_b = '0; pin_b = '0;
      model_reset();
      #3;
      check_start("R9 reset state");
      repeat (2) @(negedge clk);
      grst = 1'b0;

      drive(rd(3), rd(9), "R5 R9 R1 read image");
      drive(wr(3, 9'h15A), rd(3), "R6 R12 write A, read B same word");
      drive(rd(3), wr(7, 9'h033), "R7 show-old write on B");
      drive(rd(7), rd(3), "R10 parity returned with data");
      a = rd(3); a.ssr = 1;
      b = wr(8, 9'h1C4); b.ssr = 1;
      drive(a, b, "R3 R4 clear with and without write");
      drive(rd(8), rd(3), "R4 R3 contents after clear");
      a = wr(3, 9'h0FF); a.en = 0;
      b = wr(3, 9'h1EE); b.en = 0;
      drive(a, b, "R2 disabled write");
      drive(rd(3), rd(3), "R2 array untouched");
      drive(wr(12, 9'h011), wr(12, 9'h122), "R11 R8 dual write same word");
      drive(rd(12), rd(12), "R11 port A wins");
      drive(off(), off(), "R2 idle");
      pulse_reset();
      drive(rd(3), rd(12), "R9 image restored");

      lfsr = 32'hACE1_2468;
      for (int n = 0; n < 400; n++) begin
         op_t ra, rb;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         ra.en = lfsr[3:0] != 0; ra.we = lfsr[4]; ra.ssr = lfsr[7:5] == 0;
         ra.addr = lfsr[11:8]; ra.din = lfsr[19:12]; ra.pin = lfsr[20];
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         rb.en = lfsr[3:0] != 0; rb.we = lfsr[4]; rb.ssr = lfsr[7:5] == 0;
         rb.addr = lfsr[9] ? ra.addr : lfsr[13:10]; rb.din = lfsr[21:14]; rb.pin = lfsr[22];
         drive(ra, rb, "R1 mixed traffic");
      end
      drive(off(), off(), "R2 final idle");
      repeat (3) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule